// File: doc/BRIEF.md
# Interrupt Acceptance and Handler Entry Unit

This unit decides, at each instruction boundary, whether a 32-bit core must take an interrupt, and which one. It also produces the register values the core loads when it enters the handler. There are three kinds of request:

- a non-maskable pin, detected on its rising edge;
- a 4-bit external level bus;
- request lines from five on-chip sources: timer, real-time clock, serial port, clock generator and refresh unit.

The per-source priority levels of the on-chip sources are held in a small register block, which is written over a plain write strobe.

When a request is taken, the unit raises `accept` for one clock. In that same clock it presents the saved PC, the saved status word, the new status word, the handler address and an event code. These outputs then keep their values until the next acceptance. All pins are plain control and status pins; no port has back-pressure. The core must sample the outputs in the cycle `accept` is high. The register write port is always ready.

Top module: `irq_entry_unit`

## Requirements
- R1: A request is taken only on a rising clock edge at which `insn_boundary` is 1. `accept` is high in the cycle after that edge.
- R2: While the block bit `sr_in[28]` is 1, no request of any kind is taken.
- R3: A rising edge on `nmi_pin` (low in one sampled cycle, high in the next) is latched as pending. A high level seen first at reset is not an edge. A pending NMI is taken whatever the mask `sr_in[7:4]` holds, and it wins over every other request. Taking it clears the pending latch; a new edge in the same cycle sets it again. The event code is 0x1C0.
- R4: The external level on `irl_level` is taken when the mask `sr_in[7:4]` is strictly lower than that level. Level 0 never qualifies. The event code is 0x200 + level × 0x20.
- R5: On-chip request bit i of `periph_req` is taken when the mask is strictly lower than that source's programmed priority. Priority 0 means never. The bits are 0 timer, 1 real-time clock, 2 serial, 3 clock generator, 4 refresh. Their event codes are 0x400, 0x480, 0x500, 0x560 and 0x580.
- R6: A write with `reg_addr`=0 loads the priorities from `reg_wdata`: timer [3:0], real-time clock [7:4], serial [11:8], clock generator [15:12]. A write with `reg_addr`=1 loads the refresh priority from [3:0] and ignores bits [15:4]. All priorities reset to 0.
- R7: Among qualifying non-NMI requests, the highest level wins. At equal level the external request wins. Equal on-chip levels are resolved in the order timer, real-time clock, serial, clock generator, refresh.
- R8: On acceptance the outputs are loaded as follows:
  - `spc_out` = `next_pc`
  - `ssr_out` = `sr_in`
  - `sr_new` = `sr_in` with bits 28, 29 and 30 set and every other bit, including the mask, unchanged
  - `handler_pc` = `vbr` + 0x600
- R9: `accept` is high for one cycle per taken request. Without an acceptance, all the result outputs keep their values.
- R10: During reset all outputs are 0, no NMI is pending and all priorities are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request pin, rising-edge sensitive |
| irl_level | input | 4 | External request level, 0 means none |
| periph_req | input | 5 | On-chip request lines, bit order as in R5 |
| sr_in | input | 32 | Current status word |
| next_pc | input | 32 | PC of the instruction after the boundary |
| vbr | input | 32 | Vector base |
| insn_boundary | input | 1 | High when the core is at an instruction boundary |
| reg_wr | input | 1 | Priority register write strobe |
| reg_addr | input | 1 | Priority register select |
| reg_wdata | input | 16 | Priority register write data |
| accept | output | 1 | One-cycle acceptance pulse |
| spc_out | output | 32 | Saved PC |
| ssr_out | output | 32 | Saved status word |
| sr_new | output | 32 | Status word for handler entry |
| handler_pc | output | 32 | Handler entry address |
| evt_code | output | 12 | Event code of the taken request |

## Verification
Most wrong internal states show up at the ports within one cycle of the next boundary at which a request contends. Two examples:
- A corrupted priority field shows as a wrong `evt_code`, or as a missing or extra `accept`, in the first cycle a request competes.
- An NMI latch that is stuck set, or fails to clear, shows as a second 0x1C0 acceptance one cycle after the first. A latch that misses an edge shows as a missing acceptance once the block bit drops.

The bench compares every output against a behavioural model on every clock. It therefore catches a divergence in the same cycle, and the held values expose stale or overwritten results between acceptances.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int XLEN        = 32;
  localparam int LVL_W       = 4;
  localparam int NUM_PERIPH  = 5;
  localparam int EVT_W       = 12;
  localparam int FIELDS_PER_REG = 4;

  localparam int SR_MASK_LO  = 4;
  localparam int SR_BL       = 28;
  localparam int SR_RB       = 29;
  localparam int SR_MD       = 30;

  localparam logic [EVT_W-1:0] EVT_NMI      = 12'h1C0;
  localparam logic [EVT_W-1:0] EVT_EXT_BASE = 12'h200;
  localparam int               EXT_SHIFT    = 5;
  localparam logic [XLEN-1:0]  HANDLER_OFS  = 32'h0000_0600;

  typedef enum logic [2:0] {
    SRC_TMR = 3'd0,
    SRC_RTC = 3'd1,
    SRC_SER = 3'd2,
    SRC_CKG = 3'd3,
    SRC_REF = 3'd4
  } periph_e;

  function automatic logic [EVT_W-1:0] periph_evt(input int idx);
    case (idx)
      0:       return 12'h400;
      1:       return 12'h480;
      2:       return 12'h500;
      3:       return 12'h560;
      default: return 12'h580;
    endcase
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int NUM_SRC  = 5,
  parameter int LVL_W    = 4,
  parameter int FIELDS   = 4,
  localparam int NUM_REGS = (NUM_SRC + FIELDS - 1) / FIELDS,
  localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int DATA_W   = FIELDS * LVL_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_SRC-1:0][LVL_W-1:0]  prio_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
    localparam int RI = i / FIELDS;
    localparam int FI = i % FIELDS;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_o[i] <= '0;
      end else if (wr_en && (wr_addr == RI[ADDR_W-1:0])) begin
        prio_o[i] <= wr_data[FI*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic take,
  output logic pending_o
);
  logic pin_q;
  logic rise;

  assign rise = pin & ~pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= 1'b1;
      pending_o <= 1'b0;
    end else begin
      pin_q     <= pin;
      pending_o <= (pending_o & ~take) | rise;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_entry_pkg::*;
#(
  parameter int NUM_SRC = NUM_PERIPH,
  parameter int LW      = LVL_W,
  parameter int EW      = EVT_W
) (
  input  logic [LW-1:0]                mask,
  input  logic [LW-1:0]                ext_lvl,
  input  logic [NUM_SRC-1:0]           req,
  input  logic [NUM_SRC-1:0][LW-1:0]   prio,
  output logic                         hit,
  output logic [EW-1:0]                evt
);
  logic [LW-1:0] best_lvl;
  logic [EW-1:0] best_evt;

  always_comb begin
    best_lvl = ext_lvl;
    best_evt = EVT_EXT_BASE + (EW'(ext_lvl) << EXT_SHIFT);
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (prio[i] > best_lvl)) begin
        best_lvl = prio[i];
        best_evt = periph_evt(i);
      end
    end
    hit = best_lvl > mask;
    evt = best_evt;
  end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic [3:0]        irl_level,
  input  logic [4:0]        periph_req,
  input  logic [31:0]       sr_in,
  input  logic [31:0]       next_pc,
  input  logic [31:0]       vbr,
  input  logic              insn_boundary,
  input  logic              reg_wr,
  input  logic [0:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic              accept,
  output logic [31:0]       spc_out,
  output logic [31:0]       ssr_out,
  output logic [31:0]       sr_new,
  output logic [31:0]       handler_pc,
  output logic [11:0]       evt_code
);
  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << SR_BL) | (XLEN'(1) << SR_RB) | (XLEN'(1) << SR_MD);

  logic [NUM_PERIPH-1:0][LVL_W-1:0] prio;
  logic                             nmi_pend;
  logic                             pick_hit;
  logic [EVT_W-1:0]                 pick_evt;
  logic                             open_win;
  logic                             take_nmi;
  logic                             take_lvl;

  irq_prio_regs #(
    .NUM_SRC (NUM_PERIPH),
    .LVL_W   (LVL_W),
    .FIELDS  (FIELDS_PER_REG)
  ) prio_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .prio_o  (prio)
  );

  irq_nmi_latch nmi_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (nmi_pin),
    .take      (take_nmi),
    .pending_o (nmi_pend)
  );

  irq_pick #(
    .NUM_SRC (NUM_PERIPH),
    .LW      (LVL_W),
    .EW      (EVT_W)
  ) pick_i (
    .mask    (sr_in[SR_MASK_LO +: LVL_W]),
    .ext_lvl (irl_level),
    .req     (periph_req),
    .prio    (prio),
    .hit     (pick_hit),
    .evt     (pick_evt)
  );

  assign open_win = insn_boundary & ~sr_in[SR_BL];
  assign take_nmi = open_win & nmi_pend;
  assign take_lvl = open_win & ~nmi_pend & pick_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept     <= 1'b0;
      spc_out    <= '0;
      ssr_out    <= '0;
      sr_new     <= '0;
      handler_pc <= '0;
      evt_code   <= '0;
    end else begin
      accept <= take_nmi | take_lvl;
      if (take_nmi | take_lvl) begin
        spc_out    <= next_pc;
        ssr_out    <= sr_in;
        sr_new     <= sr_in | ENTRY_SET;
        handler_pc <= vbr + HANDLER_OFS;
        evt_code   <= take_nmi ? EVT_NMI : pick_evt;
      end
    end
  end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_boundary,
  input logic [31:0] sr_in,
  input logic [31:0] next_pc,
  input logic [31:0] vbr,
  input logic        accept,
  input logic [31:0] spc_out,
  input logic [31:0] ssr_out,
  input logic [31:0] sr_new,
  input logic [31:0] handler_pc,
  input logic [11:0] evt_code
);
  a_r1_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(insn_boundary));

  a_r2_blocked_by_bl: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !$past(sr_in[28]));

  a_r8_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (sr_new[30:28] == 3'b111));

  a_r8_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (sr_new[7:4] == ssr_out[7:4]));

  a_r8_saved_state: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (ssr_out == $past(sr_in)) && (spc_out == $past(next_pc)));

  a_r8_handler_addr: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (handler_pc == $past(vbr) + 32'h600));

  a_r9_hold_event: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> $stable(evt_code) && $stable(sr_new) && $stable(handler_pc));
endmodule

bind irq_entry_unit irq_entry_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_boundary (insn_boundary),
  .sr_in         (sr_in),
  .next_pc       (next_pc),
  .vbr           (vbr),
  .accept        (accept),
  .spc_out       (spc_out),
  .ssr_out       (ssr_out),
  .sr_new        (sr_new),
  .handler_pc    (handler_pc),
  .evt_code      (evt_code)
);

// File: tb/irq_entry_unit_tb_top.sv
`timescale 1ns/1ps
module irq_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pin = 1'b0;
  logic [3:0]  irl_level = '0;
  logic [4:0]  periph_req = '0;
  logic [31:0] sr_in = 32'h0000_00F0;
  logic [31:0] next_pc = 32'h1000;
  logic [31:0] vbr = 32'h8000_0000;
  logic        insn_boundary = 1'b1;
  logic        reg_wr = 1'b0;
  logic [0:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        accept;
  logic [31:0] spc_out, ssr_out, sr_new, handler_pc;
  logic [11:0] evt_code;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  irq_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irl_level(irl_level),
    .periph_req(periph_req), .sr_in(sr_in), .next_pc(next_pc), .vbr(vbr),
    .insn_boundary(insn_boundary), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .accept(accept), .spc_out(spc_out),
    .ssr_out(ssr_out), .sr_new(sr_new), .handler_pc(handler_pc),
    .evt_code(evt_code)
  );

  // behavioural reference
  int          m_prio [5];
  bit          m_prev, m_pend;
  bit          e_acc;
  logic [31:0] e_spc, e_ssr, e_sr, e_hpc, e_evt;
  int          unit_code [5] = '{32'h400, 32'h480, 32'h500, 32'h560, 32'h580};

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      foreach (m_prio[i]) m_prio[i] = 0;
      m_prev = 1; m_pend = 0; e_acc = 0;
      e_spc = 0; e_ssr = 0; e_sr = 0; e_hpc = 0; e_evt = 0;
    end else begin
      bit took_nmi;
      bit take;
      int best;
      int code;
      took_nmi = 0; take = 0; code = 0;
      if (insn_boundary && !sr_in[28]) begin
        if (m_pend) begin
          take = 1; took_nmi = 1; code = 32'h1C0;
        end else begin
          best = int'(irl_level);
          code = 32'h200 + best * 32;
          for (int i = 0; i < 5; i++)
            if (periph_req[i] && m_prio[i] > best) begin
              best = m_prio[i]; code = unit_code[i];
            end
          take = best > int'(sr_in[7:4]);
        end
      end
      e_acc = take;
      if (take) begin
        e_spc = next_pc; e_ssr = sr_in; e_sr = sr_in | 32'h7000_0000;
        e_hpc = vbr + 32'h600; e_evt = code;
      end
      m_pend = (m_pend && !took_nmi) || (nmi_pin && !m_prev);
      m_prev = nmi_pin;
      if (reg_wr)
        for (int i = 0; i < 5; i++)
          if (int'(reg_addr) == i / 4) m_prio[i] = int'((reg_wdata >> ((i % 4) * 4)) & 16'hF);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R9 accept vs model", 32'(accept), 32'(e_acc));
      chk("R8 spc vs model", spc_out, e_spc);
      chk("R8 ssr vs model", ssr_out, e_ssr);
      chk("R8 sr_new vs model", sr_new, e_sr);
      chk("R8 handler vs model", handler_pc, e_hpc);
      chk("R7 evt vs model", 32'(evt_code), e_evt);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(); cyc();
    chk("R10 accept in reset", 32'(accept), 0);
    chk("R10 evt in reset", 32'(evt_code), 0);
    chk("R10 sr_new in reset", sr_new, 0);
    rst_n = 1;
    cyc();
    // R6 program priorities: timer 5, rtc 5, serial 9, clkgen 0, refresh 3
    reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0955; cyc();
    reg_addr = 1; reg_wdata = 16'hFFF3; cyc();
    reg_wr = 0; cyc();
    // R4 external level above mask
    sr_in = 32'h30; irl_level = 6; cyc();
    chk("R4 ext accepted", 32'(accept), 1);
    chk("R4 ext code", 32'(evt_code), 32'h2C0);
    irl_level = 0; cyc();
    chk("R9 single pulse", 32'(accept), 0);
    chk("R9 evt held", 32'(evt_code), 32'h2C0);
    // R4 strictness
    sr_in = 32'h60; irl_level = 6; cyc();
    chk("R4 equal level rejected", 32'(accept), 0);
    // R1 boundary
    sr_in = 32'h0; insn_boundary = 0; cyc();
    chk("R1 no boundary", 32'(accept), 0);
    insn_boundary = 1;
    // R2 block bit
    sr_in = 32'h1000_0000; cyc();
    chk("R2 BL blocks level", 32'(accept), 0);
    irl_level = 0;
    // R3 NMI
    sr_in = 32'h1000_00F0; nmi_pin = 1; cyc();
    chk("R3 BL holds NMI", 32'(accept), 0);
    cyc();
    chk("R3 still held", 32'(accept), 0);
    sr_in = 32'h0000_00F0; cyc();
    chk("R3 NMI taken over mask", 32'(accept), 1);
    chk("R3 NMI code", 32'(evt_code), 32'h1C0);
    cyc();
    chk("R3 pending cleared", 32'(accept), 0);
    nmi_pin = 0;
    // R7 ties
    sr_in = 32'h0; irl_level = 5; periph_req = 5'b00001; cyc();
    chk("R7 ext wins tie", 32'(evt_code), 32'h2A0);
    irl_level = 0; periph_req = 5'b00011; cyc();
    chk("R7 timer before rtc", 32'(evt_code), 32'h400);
    periph_req = 5'b00110; cyc();
    chk("R7 higher level serial", 32'(evt_code), 32'h500);
    // R5 priority zero and refresh
    periph_req = 5'b01000; cyc(); cyc();
    chk("R5 priority 0 never", 32'(accept), 0);
    sr_in = 32'h20; periph_req = 5'b10000; cyc();
    chk("R5 refresh accepted", 32'(accept), 1);
    chk("R5 refresh code", 32'(evt_code), 32'h580);
    sr_in = 32'h30; cyc();
    chk("R5 mask equal rejects", 32'(accept), 0);
    // R6 upper bits of second register ignored
    reg_wr = 1; reg_addr = 1; reg_wdata = 16'hA000; cyc();
    reg_wr = 0; sr_in = 32'h0; cyc();
    chk("R6 refresh field zero", 32'(accept), 0);
    periph_req = 0;
    // R8 entry values
    next_pc = 32'hDEAD_BEE0; vbr = 32'h1234_0000; sr_in = 32'h0000_0012; irl_level = 9; cyc();
    chk("R8 spc", spc_out, 32'hDEAD_BEE0);
    chk("R8 ssr", ssr_out, 32'h0000_0012);
    chk("R8 sr_new", sr_new, 32'h7000_0012);
    chk("R8 handler", handler_pc, 32'h1234_0600);
    irl_level = 0; cyc();
    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      nmi_pin       = ($urandom % 8) == 0;
      irl_level     = 4'($urandom);
      periph_req    = 5'($urandom);
      sr_in         = $urandom;
      if (($urandom % 3) != 0) sr_in[28] = 1'b0;
      next_pc       = $urandom;
      vbr           = $urandom;
      insn_boundary = ($urandom % 4) != 0;
      reg_wr        = ($urandom % 10) == 0;
      reg_addr      = 1'($urandom);
      reg_wdata     = 16'($urandom);
      cyc();
    end
    finish_run();
  end
endmodule